// File: doc/BRIEF.md
# Banked Dual-Space Scratchpad Arbiter

This block is an on-chip scratchpad with two address spaces, X and Y. Each space holds two 4 KB pages, so the block has four single-port page banks. Three requesters share them: a 16-bit DSP port for the X data path, a second 16-bit DSP port for the Y data path, and a general load/store port that moves 16-bit or 32-bit words. Each request is decoded to one page. Requests that fall on different pages finish together in one cycle. When two requests fall on the same page, one of them wins and the others are held back.

Every port uses a valid/ready handshake with combinational ready. A requester raises `*_valid` with address, direction and write data. The access completes in the first cycle in which `*_ready` is high. Read data and the error flag are valid in that same cycle, and a write lands on the closing clock edge of that cycle. While ready is low, the requester must hold valid and every request field unchanged. A request that has not completed has no effect on memory. Back-pressure lasts only as long as a page conflict lasts. A request that was stalled in the previous cycle outranks fresh requests, so a loser normally waits exactly one cycle.

Words are stored big-endian: byte offset 0 of a word is bits 31:24. A halfword access picks the upper or lower half of the word by address bit 1.

Top module: `xy_scratch_arb`

## Requirements
- R1: Only four 4096-byte pages hold storage. They start at 0x05007000 and 0x05008000 (X space, page index 0 and 1) and at 0x05017000 and 0x05018000 (Y space, page index 2 and 3). Any other 29-bit address raises `*_err` and `*_ready` in the same cycle and writes nothing.
- R2: DSP port accesses and 16-bit load/store accesses need address bit 0 clear. 32-bit load/store accesses need address bits 1:0 clear. A misaligned request raises `*_err` and `*_ready` in the same cycle and writes nothing.
- R3: Lanes are big-endian. A halfword at address bit 1 = 0 is word bits 31:16, and at bit 1 = 1 it is bits 15:0. On the load/store port, 16-bit data travels in bits 15:0, and read bits 31:16 are zero for a 16-bit read. `lb_wide` = 1 selects 32-bit.
- R4: A valid, well-formed request with no rival on its page is ready in the same cycle. Read data is valid in that cycle. A completed write is visible to a read in the following cycle.
- R5: X-port and Y-port requests to different pages both complete in the same cycle.
- R6: Among requests to one page, none of which was stalled in the previous cycle, the fixed order is X port, then Y port, then load/store port. Exactly one request per page completes per cycle.
- R7: A request stalled in the previous cycle outranks fresh requests. Ties among stalled requests fall back to the R6 order. So a sole stalled request that is still held completes in the next cycle.
- R8: A request whose ready is low leaves memory unchanged. Requesters hold valid and all fields until ready.
- R9: Ready is never high without valid. After reset, no request counts as previously stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xb_valid | input | 1 | X-port request valid |
| xb_ready | output | 1 | X-port request completes this cycle |
| xb_addr | input | 29 | X-port byte address |
| xb_we | input | 1 | X-port write (1) or read (0) |
| xb_wdata | input | 16 | X-port write halfword |
| xb_rdata | output | 16 | X-port read halfword |
| xb_err | output | 1 | X-port reserved or misaligned address |
| yb_valid | input | 1 | Y-port request valid |
| yb_ready | output | 1 | Y-port request completes this cycle |
| yb_addr | input | 29 | Y-port byte address |
| yb_we | input | 1 | Y-port write (1) or read (0) |
| yb_wdata | input | 16 | Y-port write halfword |
| yb_rdata | output | 16 | Y-port read halfword |
| yb_err | output | 1 | Y-port reserved or misaligned address |
| lb_valid | input | 1 | Load/store request valid |
| lb_ready | output | 1 | Load/store request completes this cycle |
| lb_addr | input | 29 | Load/store byte address |
| lb_we | input | 1 | Load/store write (1) or read (0) |
| lb_wide | input | 1 | 1: 32-bit access, 0: 16-bit access |
| lb_wdata | input | 32 | Load/store write data (16-bit data in bits 15:0) |
| lb_rdata | output | 32 | Load/store read data |
| lb_err | output | 1 | Load/store reserved or misaligned address |

## Verification
The only state apart from the page arrays is one "stalled last cycle" flag per port. If a flag is stuck or wrong, the next same-page contest shows it at once as a wrong `*_ready` pattern: a stalled port loses a second time, or a fresh port beats a waiting one. A wrong page decode or lane steering leaves no flag behind. It shows up only on a later read, as a halfword from the wrong page or the wrong half, or as a lost or misdirected write. The bench therefore reads back every stored word it has touched, many times over, and it places writes and reads to the same page in back-to-back cycles.

// File: rtl/xy_scratch_pkg.sv
package xy_scratch_pkg;
  localparam int ADDR_W     = 29;
  localparam int WORD_W     = 32;
  localparam int HALF_W     = 16;
  localparam int LANES      = WORD_W / 8;
  localparam int NPORT      = 3;
  localparam int NPAGE      = 4;
  localparam int PAGE_BYTES = 4096;
  localparam int PAGE_SH    = $clog2(PAGE_BYTES);
  localparam int PAGE_WORDS = PAGE_BYTES / LANES;
  localparam int IDX_W      = $clog2(PAGE_WORDS);
  localparam int PG_W       = $clog2(NPAGE);
  localparam int RANK_W     = $clog2(NPORT) + 1;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [PG_W-1:0]   pg_t;

  // Page start addresses; index 0/1 live in X space, 2/3 in Y space.
  function automatic addr_t page_base(input int p);
    case (p)
      0:       return addr_t'(29'h0500_7000);
      1:       return addr_t'(29'h0500_8000);
      2:       return addr_t'(29'h0501_7000);
      default: return addr_t'(29'h0501_8000);
    endcase
  endfunction

  // Fixed priority: port 0 (X) highest, last port (load/store) lowest.
  function automatic logic [RANK_W-2:0] port_prio(input int i);
    return (RANK_W-1)'(NPORT - 1 - i);
  endfunction
endpackage

// File: rtl/xy_addr_dec.sv
module xy_addr_dec
  import xy_scratch_pkg::*;
#(
  parameter int PBYTES = PAGE_BYTES,
  parameter int IW     = $clog2(PBYTES) - 2
) (
  input  addr_t          addr,
  input  logic           wide,
  output logic           hit,
  output pg_t            page,
  output logic [IW-1:0]  idx,
  output logic [LANES-1:0] be,
  output logic           misal
);
  localparam int SH = $clog2(PBYTES);

  logic [NPAGE-1:0] match;

  for (genvar p = 0; p < NPAGE; p++) begin : g_match
    localparam addr_t BASE = page_base(p);
    assign match[p] = (addr[ADDR_W-1:SH] == BASE[ADDR_W-1:SH]);
  end

  always_comb begin
    page = '0;
    for (int p = 0; p < NPAGE; p++)
      if (match[p]) page = pg_t'(p);
  end

  assign hit   = |match;
  assign idx   = addr[SH-1:2];
  assign misal = wide ? (addr[1:0] != 2'b00) : addr[0];
  assign be    = wide ? {LANES{1'b1}}
               : (addr[1] ? {{(LANES/2){1'b0}}, {(LANES/2){1'b1}}}
                          : {{(LANES/2){1'b1}}, {(LANES/2){1'b0}}});
endmodule

// File: rtl/xy_page_arb.sv
module xy_page_arb
  import xy_scratch_pkg::*;
(
  input  logic [NPORT-1:0]           req,
  input  logic [NPORT-1:0][PG_W-1:0] page,
  input  logic [NPORT-1:0]           aged,
  output logic [NPORT-1:0]           grant
);
  for (genvar i = 0; i < NPORT; i++) begin : g_port
    logic [NPORT-1:0] beaten_by;
    for (genvar j = 0; j < NPORT; j++) begin : g_rival
      if (j == i) begin : g_self
        assign beaten_by[j] = 1'b0;
      end else begin : g_other
        localparam logic [RANK_W-2:0] PJ = port_prio(j);
        localparam logic [RANK_W-2:0] PI = port_prio(i);
        assign beaten_by[j] = req[j] && (page[j] == page[i]) &&
                              ({aged[j], PJ} > {aged[i], PI});
      end
    end
    assign grant[i] = req[i] && !(|beaten_by);
  end
endmodule

// File: rtl/xy_page_bank.sv
module xy_page_bank #(
  parameter int WORDS = 1024,
  parameter int NLANE = 4,
  localparam int AW   = $clog2(WORDS),
  localparam int DW   = NLANE * 8
) (
  input  logic             clk,
  input  logic             en,
  input  logic             we,
  input  logic [AW-1:0]    idx,
  input  logic [NLANE-1:0] be,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata
);
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (en && we) begin
      for (int b = 0; b < NLANE; b++)
        if (be[b]) mem[idx][b*8 +: 8] <= wdata[b*8 +: 8];
    end
  end

  assign rdata = mem[idx];
endmodule

// File: rtl/xy_scratch_arb.sv
module xy_scratch_arb
  import xy_scratch_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xb_valid,
  output logic              xb_ready,
  input  logic [ADDR_W-1:0] xb_addr,
  input  logic              xb_we,
  input  logic [HALF_W-1:0] xb_wdata,
  output logic [HALF_W-1:0] xb_rdata,
  output logic              xb_err,
  input  logic              yb_valid,
  output logic              yb_ready,
  input  logic [ADDR_W-1:0] yb_addr,
  input  logic              yb_we,
  input  logic [HALF_W-1:0] yb_wdata,
  output logic [HALF_W-1:0] yb_rdata,
  output logic              yb_err,
  input  logic              lb_valid,
  output logic              lb_ready,
  input  logic [ADDR_W-1:0] lb_addr,
  input  logic              lb_we,
  input  logic              lb_wide,
  input  logic [WORD_W-1:0] lb_wdata,
  output logic [WORD_W-1:0] lb_rdata,
  output logic              lb_err
);
  localparam int PX = 0;
  localparam int PY = 1;
  localparam int PL = 2;

  logic [NPORT-1:0]              vld, wr, wide;
  logic [NPORT-1:0][ADDR_W-1:0]  adr;
  logic [NPORT-1:0][WORD_W-1:0]  wword;
  logic [NPORT-1:0]              hit, misal, bad, req, grant, rdy;
  logic [NPORT-1:0][PG_W-1:0]    pg;
  logic [NPORT-1:0][IDX_W-1:0]   idx;
  logic [NPORT-1:0][LANES-1:0]   be;
  logic [NPORT-1:0][WORD_W-1:0]  rword;
  logic [NPAGE-1:0][WORD_W-1:0]  bank_rd;
  logic [NPORT-1:0]              wait_q;
  pg_t                           pg_x, pg_y, pg_l;

  // Gather the three requesters into indexed form (0 = X, 1 = Y, 2 = L).
  assign vld  = {lb_valid, yb_valid, xb_valid};
  assign wr   = {lb_we, yb_we, xb_we};
  assign wide = {lb_wide, 1'b0, 1'b0};
  assign adr  = {lb_addr, yb_addr, xb_addr};
  assign wword[PX] = {xb_wdata, xb_wdata};
  assign wword[PY] = {yb_wdata, yb_wdata};
  assign wword[PL] = lb_wide ? lb_wdata : {lb_wdata[HALF_W-1:0], lb_wdata[HALF_W-1:0]};

  for (genvar i = 0; i < NPORT; i++) begin : g_dec
    xy_addr_dec #(.PBYTES(PAGE_BYTES), .IW(IDX_W)) dec_i (
      .addr  (adr[i]),
      .wide  (wide[i]),
      .hit   (hit[i]),
      .page  (pg[i]),
      .idx   (idx[i]),
      .be    (be[i]),
      .misal (misal[i])
    );
    assign bad[i]   = vld[i] && (!hit[i] || misal[i]);
    assign req[i]   = vld[i] && hit[i] && !misal[i];
    assign rword[i] = bank_rd[pg[i]];
  end

  xy_page_arb arb_i (
    .req   (req),
    .page  (pg),
    .aged  (wait_q),
    .grant (grant)
  );

  assign rdy = grant | bad;

  // One stalled-last-cycle flag per port lifts it above fresh traffic.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wait_q <= '0;
    else        wait_q <= vld & ~rdy;
  end

  for (genvar p = 0; p < NPAGE; p++) begin : g_bank
    logic              b_en, b_we;
    logic [IDX_W-1:0]  b_idx;
    logic [LANES-1:0]  b_be;
    logic [WORD_W-1:0] b_wd;

    always_comb begin
      b_en  = 1'b0;
      b_we  = 1'b0;
      b_idx = '0;
      b_be  = '0;
      b_wd  = '0;
      for (int i = 0; i < NPORT; i++) begin
        if (grant[i] && pg[i] == pg_t'(p)) begin
          b_en  = 1'b1;
          b_we  = wr[i];
          b_idx = idx[i];
          b_be  = be[i];
          b_wd  = wword[i];
        end
      end
    end

    xy_page_bank #(.WORDS(PAGE_WORDS), .NLANE(LANES)) bank_i (
      .clk   (clk),
      .en    (b_en),
      .we    (b_we),
      .idx   (b_idx),
      .be    (b_be),
      .wdata (b_wd),
      .rdata (bank_rd[p])
    );
  end

  function automatic logic [HALF_W-1:0] pick_half(input logic [WORD_W-1:0] w,
                                                   input logic lo);
    return lo ? w[HALF_W-1:0] : w[WORD_W-1:HALF_W];
  endfunction

  assign xb_ready = rdy[PX];
  assign yb_ready = rdy[PY];
  assign lb_ready = rdy[PL];
  assign xb_err   = bad[PX];
  assign yb_err   = bad[PY];
  assign lb_err   = bad[PL];
  assign xb_rdata = pick_half(rword[PX], adr[PX][1]);
  assign yb_rdata = pick_half(rword[PY], adr[PY][1]);
  assign lb_rdata = lb_wide ? rword[PL]
                  : {{(WORD_W-HALF_W){1'b0}}, pick_half(rword[PL], adr[PL][1])};

  assign pg_x = pg[PX];
  assign pg_y = pg[PY];
  assign pg_l = pg[PL];
endmodule

// File: rtl/xy_scratch_chk.sv
module xy_scratch_chk
  import xy_scratch_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              xb_valid, xb_ready, xb_err,
  input logic              yb_valid, yb_ready, yb_err,
  input logic              lb_valid, lb_ready, lb_err, lb_we, lb_wide,
  input logic [ADDR_W-1:0] lb_addr,
  input logic [WORD_W-1:0] lb_wdata,
  input pg_t               pg_x, pg_y, pg_l,
  input logic [NPORT-1:0]  wait_q
);
  p_err_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
    lb_valid && lb_err |-> lb_ready);

  p_err_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    xb_valid && xb_err |-> xb_ready);

  p_top_prio_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xb_valid && !wait_q[1] && !wait_q[2] |-> xb_ready);

  p_one_per_page_xy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xb_ready && yb_ready && !xb_err && !yb_err |-> pg_x != pg_y);

  p_one_per_page_xl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xb_ready && lb_ready && !xb_err && !lb_err |-> pg_x != pg_l);

  p_one_per_page_yl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    yb_ready && lb_ready && !yb_err && !lb_err |-> pg_y != pg_l);

  p_dual_dsp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xb_valid && yb_valid && !xb_err && !yb_err && pg_x != pg_y && !wait_q[2]
      |-> xb_ready && yb_ready);

  p_stall_once_l_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lb_valid && !lb_ready && !(xb_valid && !xb_ready) && !(yb_valid && !yb_ready)
      |=> !lb_valid || lb_ready);

  p_stall_once_y_r7: assert property (@(posedge clk) disable iff (!rst_n)
    yb_valid && !yb_ready && !(xb_valid && !xb_ready) && !(lb_valid && !lb_ready)
      |=> !yb_valid || yb_ready);

  p_hold_fields_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lb_valid && !lb_ready
      |=> lb_valid && $stable(lb_addr) && $stable(lb_we) && $stable(lb_wide) && $stable(lb_wdata));

  p_ready_needs_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!xb_valid |-> !xb_ready) and (!yb_valid |-> !yb_ready) and (!lb_valid |-> !lb_ready));
endmodule

bind xy_scratch_arb xy_scratch_chk chk_i (.*);

// File: tb/xy_scratch_arb_tb_top.sv
`timescale 1ns/1ps
module xy_scratch_arb_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  bit          v   [3];
  logic [28:0] a   [3];
  bit          w   [3];
  bit          wd_w[3];
  logic [31:0] d   [3];
  bit          bw  [3];
  bit          er  [3];
  bit          erdy[3];
  logic [31:0] erd [3];
  logic [31:0] model [4][1024];
  int total = 0;
  int bad = 0;

  logic        xb_ready, yb_ready, lb_ready, xb_err, yb_err, lb_err;
  logic [15:0] xb_rdata, yb_rdata;
  logic [31:0] lb_rdata;

  xy_scratch_arb dut_i (
    .clk(clk), .rst_n(rst_n),
    .xb_valid(v[0]), .xb_ready(xb_ready), .xb_addr(a[0]), .xb_we(w[0]),
    .xb_wdata(d[0][15:0]), .xb_rdata(xb_rdata), .xb_err(xb_err),
    .yb_valid(v[1]), .yb_ready(yb_ready), .yb_addr(a[1]), .yb_we(w[1]),
    .yb_wdata(d[1][15:0]), .yb_rdata(yb_rdata), .yb_err(yb_err),
    .lb_valid(v[2]), .lb_ready(lb_ready), .lb_addr(a[2]), .lb_we(w[2]),
    .lb_wide(wd_w[2]), .lb_wdata(d[2]), .lb_rdata(lb_rdata), .lb_err(lb_err)
  );

  function automatic int page_of(logic [28:0] ad);
    case (ad[28:12])
      17'h05007: return 0;
      17'h05008: return 1;
      17'h05017: return 2;
      17'h05018: return 3;
      default:   return -1;
    endcase
  endfunction

  function automatic bit is_mis(int i);
    if (i == 2 && wd_w[2]) return a[i][1:0] != 2'b00;
    return a[i][0];
  endfunction

  function automatic bit act_rdy(int i);
    return (i == 0) ? xb_ready : (i == 1) ? yb_ready : lb_ready;
  endfunction

  function automatic bit act_err(int i);
    return (i == 0) ? xb_err : (i == 1) ? yb_err : lb_err;
  endfunction

  function automatic logic [31:0] act_rd(int i);
    return (i == 0) ? {16'h0, xb_rdata} : (i == 1) ? {16'h0, yb_rdata} : lb_rdata;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic setp(int i, bit val, logic [28:0] ad, bit wr, bit wide, logic [31:0] dat);
    v[i] = val; a[i] = ad; w[i] = wr; wd_w[i] = (i == 2) ? wide : 1'b0; d[i] = dat;
  endtask

  // Compute expectations from the requirements, then sample at the falling edge.
  task automatic eval_cycle();
    for (int i = 0; i < 3; i++) begin
      int pi;
      logic [31:0] wordv;
      pi = page_of(a[i]);
      er[i] = v[i] && (pi < 0 || is_mis(i));
      erdy[i] = 1'b0;
      if (v[i] && er[i]) erdy[i] = 1'b1;
      else if (v[i]) begin
        bit lost;
        lost = 1'b0;
        for (int j = 0; j < 3; j++) begin
          if (j != i && v[j] && page_of(a[j]) == pi && !(page_of(a[j]) < 0) &&
              !is_mis(j) && ((int'(bw[j]) * 4 + 2 - j) > (int'(bw[i]) * 4 + 2 - i)))
            lost = 1'b1;
        end
        erdy[i] = !lost;
      end
      wordv = (pi >= 0) ? model[pi][a[i][11:2]] : 32'h0;
      if (i == 2 && wd_w[2]) erd[i] = wordv;
      else erd[i] = {16'h0, a[i][1] ? wordv[15:0] : wordv[31:16]};
    end
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      if (!v[i]) chk(act_rdy(i) == 1'b0, "R9 idle ready", 32'(act_rdy(i)), 32'h0);
      else begin
        chk(act_err(i) == er[i], is_mis(i) ? "R2 err" : "R1 err", 32'(act_err(i)), 32'(er[i]));
        chk(act_rdy(i) == erdy[i], er[i] ? "R1 err ready" : (bw[i] ? "R7 ready" : "R6 ready"),
            32'(act_rdy(i)), 32'(erdy[i]));
        if (erdy[i] && !er[i] && !w[i])
          chk(act_rd(i) == erd[i], "R4 read data", act_rd(i), erd[i]);
      end
    end
  endtask

  task automatic end_cycle();
    for (int i = 0; i < 3; i++) begin
      if (v[i] && erdy[i] && !er[i] && w[i]) begin
        int pi;
        pi = page_of(a[i]);
        if (i == 2 && wd_w[2]) model[pi][a[i][11:2]] = d[i];
        else if (a[i][1]) model[pi][a[i][11:2]][15:0] = d[i][15:0];
        else model[pi][a[i][11:2]][31:16] = d[i][15:0];
      end
      bw[i] = v[i] && !erdy[i];
    end
    @(posedge clk);
    #1;
    for (int i = 0; i < 3; i++) if (erdy[i]) v[i] = 1'b0;
  endtask

  task automatic one_cycle();
    eval_cycle();
    end_cycle();
  endtask

  function automatic logic [28:0] rand_addr(int i, bit wide);
    logic [28:0] base;
    int idx, wi;
    idx = int'($urandom % 32);
    wi = (idx < 16) ? idx : 1008 + idx - 16;
    case ($urandom % 4)
      0: base = 29'h0500_7000;
      1: base = 29'h0500_8000;
      2: base = 29'h0501_7000;
      default: base = 29'h0501_8000;
    endcase
    base = base + 29'(wi * 4);
    if (!wide) base[1] = 1'($urandom % 2);
    case ($urandom % 24)
      0: base[0] = 1'b1;
      1: base = 29'h0500_9000 + 29'(wi * 4);
      2: base = 29'h0500_6FFC;
      3: if (i == 2 && wide) base[1] = 1'b1;
      default: ;
    endcase
    return base;
  endfunction

  task automatic gen(int i);
    bit wide;
    wide = (i == 2) ? bit'($urandom % 2) : 1'b0;
    setp(i, ($urandom % 4) != 0, rand_addr(i, wide), bit'($urandom % 2), wide, $urandom);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < 3; i++) begin setp(i, 0, 29'h0, 0, 0, 0); bw[i] = 0; end
    repeat (3) @(posedge clk);
    #1;
    chk(!xb_ready && !yb_ready && !lb_ready, "R9 reset ready", {xb_ready, yb_ready, lb_ready}, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // Fill the tracked words of every page through the load/store port.
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < 32; k++) begin
        logic [28:0] b;
        int wi;
        b = (p == 0) ? 29'h0500_7000 : (p == 1) ? 29'h0500_8000 :
            (p == 2) ? 29'h0501_7000 : 29'h0501_8000;
        wi = (k < 16) ? k : 1008 + k - 16;
        setp(2, 1, b + 29'(wi * 4), 1, 1, $urandom);
        one_cycle();
      end
    end

    // R3 lanes and R5 dual DSP issue on different pages.
    setp(2, 1, 29'h0500_7010, 1, 1, 32'h1122_3344); one_cycle();
    setp(2, 1, 29'h0501_8010, 1, 1, 32'hAABB_CCDD); one_cycle();
    setp(0, 1, 29'h0500_7010, 0, 0, 0);
    setp(1, 1, 29'h0501_8012, 0, 0, 0);
    eval_cycle();
    chk(xb_ready && yb_ready, "R5 both ready", {xb_ready, yb_ready}, 2'b11);
    chk(xb_rdata == 16'h1122, "R3 upper half", xb_rdata, 16'h1122);
    chk(yb_rdata == 16'hCCDD, "R3 lower half", yb_rdata, 16'hCCDD);
    end_cycle();
    setp(2, 1, 29'h0500_7012, 1, 0, 32'hFFFF_5566); one_cycle();
    setp(2, 1, 29'h0500_7010, 0, 1, 0);
    eval_cycle();
    chk(lb_rdata == 32'h1122_5566, "R3 half write lane", lb_rdata, 32'h1122_5566);
    end_cycle();
    setp(2, 1, 29'h0500_7012, 0, 0, 0);
    eval_cycle();
    chk(lb_rdata == 32'h0000_5566, "R3 half read zero-extend", lb_rdata, 32'h0000_5566);
    end_cycle();

    // R2 misaligned writes leave memory unchanged.
    setp(2, 1, 29'h0500_7012, 1, 1, 32'hDEAD_DEAD); one_cycle();
    setp(0, 1, 29'h0500_7011, 1, 0, 32'h0000_BEEF); one_cycle();
    setp(2, 1, 29'h0500_7010, 0, 1, 0);
    eval_cycle();
    chk(lb_rdata == 32'h1122_5566, "R2 no write on misalign", lb_rdata, 32'h1122_5566);
    end_cycle();

    // R1 reserved and outside addresses; top word of a page is valid.
    setp(2, 1, 29'h0500_9000, 1, 1, 32'h0);
    eval_cycle();
    chk(lb_err && lb_ready, "R1 reserved page", {lb_err, lb_ready}, 2'b11);
    end_cycle();
    setp(2, 1, 29'h0502_7000, 0, 1, 0);
    eval_cycle();
    chk(lb_err && lb_ready, "R1 outside window", {lb_err, lb_ready}, 2'b11);
    end_cycle();
    setp(1, 1, 29'h0501_8FFE, 0, 0, 0);
    eval_cycle();
    chk(!yb_err && yb_ready, "R1 last halfword valid", {yb_err, yb_ready}, 2'b01);
    end_cycle();

    // R6/R8/R7/R4: stalled write, then aged winner, then write visible.
    begin
      logic [31:0] old;
      old = model[1][0];
      setp(0, 1, 29'h0500_8000, 0, 0, 0);
      setp(2, 1, 29'h0500_8000, 1, 1, 32'hDEAD_BEEF);
      eval_cycle();
      chk(xb_ready && !lb_ready, "R6 dsp beats load/store", {xb_ready, lb_ready}, 2'b10);
      chk(xb_rdata == old[31:16], "R8 stalled write no effect", xb_rdata, old[31:16]);
      end_cycle();
      setp(0, 1, 29'h0500_8000, 0, 0, 0);
      eval_cycle();
      chk(lb_ready && !xb_ready, "R7 stalled port wins", {xb_ready, lb_ready}, 2'b01);
      end_cycle();
      eval_cycle();
      chk(xb_ready && xb_rdata == 16'hDEAD, "R4 write visible next cycle", xb_rdata, 16'hDEAD);
      end_cycle();
    end

    // R6 X over Y on one page, then R7 tie among two stalled ports.
    setp(0, 1, 29'h0501_7000, 0, 0, 0);
    setp(1, 1, 29'h0501_7004, 0, 0, 0);
    setp(2, 1, 29'h0501_7008, 0, 1, 0);
    eval_cycle();
    chk(xb_ready && !yb_ready && !lb_ready, "R6 x over y", {xb_ready, yb_ready, lb_ready}, 3'b100);
    end_cycle();
    eval_cycle();
    chk(yb_ready && !lb_ready, "R7 stalled tie order", {yb_ready, lb_ready}, 2'b10);
    end_cycle();
    one_cycle();

    // Constrained random traffic.
    for (int n = 0; n < 4000; n++) begin
      for (int i = 0; i < 3; i++) if (!v[i]) gen(i);
      one_cycle();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule